// File: doc/BRIEF.md
# Paged Nonvolatile Write Buffer

This block is the staging buffer between a serial programming command decoder and a nonvolatile memory array. The decoder hands it one command per cycle. Load commands place a value into the buffer slot chosen by the low address bits. A commit command then replays the buffer towards the array as a stream of write strobes. The strobes go to the page chosen by the high address bits of the commit command. Cell programming itself is not modelled, apart from a fixed hold time after each commit.

The block has two buffers. The word buffer serves program memory. Each 16-bit entry is filled by a low-byte load followed by a high-byte load. An entry reaches the array only when both halves arrived in that order. The byte buffer serves data memory. It remembers which slots were loaded, so a page commit touches those slots and no others. A third path writes one data byte directly: it issues an erase strobe for the location and then a program strobe. Busy status can be polled while a commit runs. Any command that arrives while busy is thrown away and counted.

Top module: `nvm_page_buffer`

## Requirements
- R1: While reset is high and on the first cycle after it, busy is 0, err_cnt is 0 and wr_en is 0.
- R2: Opcode 0 loads the low byte and opcode 1 loads the high byte of word slot cmd_addr[OFF_BITS-1:0]. Opcode 2 commits the word buffer. It emits one wr_en strobe with wr_space=0, wr_erase=0 and wr_data={high,low} for each complete slot, in ascending slot order. The strobe address is {cmd_addr[ADDR_W-1:OFF_BITS] of the commit, slot}, so the offset bits of the commit address are ignored.
- R3: A high-byte load to a slot whose low byte was not yet loaded marks that slot invalid. The slot is then not written by the next word commit, even if both halves are loaded afterwards.
- R4: A word slot that received only its low byte is not written by a word commit.
- R5: Opcode 3 stores cmd_data[7:0] into byte slot cmd_addr[OFF_BITS-1:0], and the last load to a slot wins. Opcode 4 emits strobes with wr_space=1 and wr_data[7:0] set to the stored byte, for the loaded slots only, at {commit page, slot}. Unloaded locations receive no strobe.
- R6: Opcode 5 emits an erase strobe (wr_en=1, wr_erase=1, wr_space=1, wr_data=16'h00FF) at the full cmd_addr. On the next cycle it emits a program strobe (wr_erase=0) carrying cmd_data[7:0] at the same address.
- R7: Busy rises on the cycle after an accepted opcode 2, 4 or 5. It stays high for 2^OFF_BITS + BUSY_CYCLES cycles after a page commit, and for 2 + BUSY_CYCLES cycles after opcode 5. Loads never raise busy.
- R8: A command presented while busy is dropped and changes no buffer. Each dropped command increments err_cnt by one, and err_cnt saturates at all ones.
- R9: Once a page commit completes, the loaded marks of that buffer are cleared, so a repeated commit with no new loads emits no strobe.
- R10: Opcodes 6 and 7 have no effect: they do not set busy, change err_cnt, emit strobes or load any slot.
- R11: wr_en is only ever high while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode (see requirements) |
| cmd_addr | input | ADDR_W | {page, slot} address |
| cmd_data | input | 8 | Command data byte |
| busy | output | 1 | Commit or single write in progress |
| err_cnt | output | CNT_W | Saturating count of dropped commands |
| wr_en | output | 1 | Array write strobe |
| wr_erase | output | 1 | Strobe is an erase rather than a program |
| wr_space | output | 1 | 0 program memory, 1 data memory |
| wr_addr | output | ADDR_W | Array address of the strobe |
| wr_data | output | 16 | Strobe data (data memory uses bits 7:0) |

## Verification
The bench builds the block with OFF_BITS=3, PAGE_BITS=4, BUSY_CYCLES=5 and CNT_W=3. Eight-slot pages let every commit walk the whole buffer, reaching the last slot and the end of the hold window within a few dozen cycles. A three-bit error counter can be driven into saturation by a short burst of commands sent during one commit. A model of both arrays, preloaded with marker values, records every strobe. This shows which locations a commit touched and which kept their markers.

// File: rtl/nvm_pb_pkg.sv
package nvm_pb_pkg;

    typedef enum logic [2:0] {
        OP_WLOAD_LO = 3'd0,
        OP_WLOAD_HI = 3'd1,
        OP_WCOMMIT  = 3'd2,
        OP_BLOAD    = 3'd3,
        OP_BCOMMIT  = 3'd4,
        OP_BWRITE   = 3'd5,
        OP_RSVD6    = 3'd6,
        OP_RSVD7    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_ERASE,
        ST_PROG,
        ST_HOLD
    } st_e;

    typedef enum logic {
        SP_WORD = 1'b0,
        SP_BYTE = 1'b1
    } space_e;

    typedef struct packed {
        logic lo_v;
        logic hi_v;
        logic bad;
    } wflags_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic logic word_complete(wflags_t f);
        return f.lo_v & f.hi_v & ~f.bad;
    endfunction

    function automatic logic op_starts_busy(logic [2:0] op);
        return (op == OP_WCOMMIT) || (op == OP_BCOMMIT) || (op == OP_BWRITE);
    endfunction

endpackage

// File: rtl/nvm_pb_wordbuf.sv
module nvm_pb_wordbuf
    import nvm_pb_pkg::*;
#(
    parameter int OFF_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [OFF_BITS-1:0] ld_off,
    input  logic [7:0]          ld_data,
    input  logic                clr,
    input  logic [OFF_BITS-1:0] rd_idx,
    output logic                rd_ok,
    output logic [15:0]         rd_word
);
    localparam int DEPTH = 1 << OFF_BITS;

    logic [DEPTH-1:0] ok_vec;
    logic [15:0]      word_vec [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [OFF_BITS-1:0] IDX = OFF_BITS'(g);
        wflags_t    fl_q;
        logic [7:0] lo_q;
        logic [7:0] hi_q;
        logic       hit;

        assign hit = (ld_off == IDX);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                fl_q <= '0;
            end else if (ld_lo && hit) begin
                fl_q.lo_v <= 1'b1;
            end else if (ld_hi && hit) begin
                if (!fl_q.lo_v) begin
                    fl_q.bad <= 1'b1;
                end else begin
                    fl_q.hi_v <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (ld_lo && hit) begin
                lo_q <= ld_data;
            end
            if (ld_hi && hit) begin
                hi_q <= ld_data;
            end
        end

        assign ok_vec[g]   = word_complete(fl_q);
        assign word_vec[g] = {hi_q, lo_q};
    end

    assign rd_ok   = ok_vec[rd_idx];
    assign rd_word = word_vec[rd_idx];

endmodule

// File: rtl/nvm_pb_bytebuf.sv
module nvm_pb_bytebuf #(
    parameter int OFF_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld,
    input  logic [OFF_BITS-1:0] ld_off,
    input  logic [7:0]          ld_data,
    input  logic                clr,
    input  logic [OFF_BITS-1:0] rd_idx,
    output logic                rd_ok,
    output logic [7:0]          rd_byte
);
    localparam int DEPTH = 1 << OFF_BITS;

    logic [DEPTH-1:0] vld_vec;
    logic [7:0]       byte_vec [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [OFF_BITS-1:0] IDX = OFF_BITS'(g);
        logic       vld_q;
        logic [7:0] val_q;
        logic       hit;

        assign hit = ld && (ld_off == IDX);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vld_q <= 1'b0;
            end else if (hit) begin
                vld_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit) begin
                val_q <= ld_data;
            end
        end

        assign vld_vec[g]  = vld_q;
        assign byte_vec[g] = val_q;
    end

    assign rd_ok   = vld_vec[rd_idx];
    assign rd_byte = byte_vec[rd_idx];

endmodule

// File: rtl/nvm_pb_seq.sv
module nvm_pb_seq
    import nvm_pb_pkg::*;
#(
    parameter int OFF_BITS    = 6,
    parameter int PAGE_BITS   = 7,
    parameter int BUSY_CYCLES = 64,
    parameter int CNT_W       = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [OFF_BITS+PAGE_BITS-1:0] cmd_addr,
    input  logic [7:0]                   cmd_data,
    input  logic                         ent_ok,
    input  logic [15:0]                  ent_data,
    output logic                         accept,
    output logic                         busy,
    output logic [CNT_W-1:0]             err_cnt,
    output logic [OFF_BITS-1:0]          walk_idx,
    output logic                         walk_byte,
    output logic                         clr_word,
    output logic                         clr_byte,
    output logic                         wr_en,
    output logic                         wr_erase,
    output logic                         wr_space,
    output logic [OFF_BITS+PAGE_BITS-1:0] wr_addr,
    output logic [15:0]                  wr_data
);
    localparam int ADDR_W = OFF_BITS + PAGE_BITS;
    localparam int DEPTH  = 1 << OFF_BITS;
    localparam int HOLD_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [OFF_BITS-1:0] LAST_IDX  = OFF_BITS'(DEPTH - 1);
    localparam logic [HOLD_W-1:0]   HOLD_LOAD = HOLD_W'(BUSY_CYCLES - 1);
    localparam logic [CNT_W-1:0]    CNT_MAX   = '1;

    st_e                  st_q;
    space_e               space_q;
    logic                 page_q;
    logic [PAGE_BITS-1:0] pg_q;
    logic [OFF_BITS-1:0]  idx_q;
    logic [ADDR_W-1:0]    s_addr_q;
    logic [7:0]           s_data_q;
    logic [HOLD_W-1:0]    hold_q;
    logic [CNT_W-1:0]     err_q;
    logic                 drop;
    logic                 hold_done;

    assign busy      = (st_q != ST_IDLE);
    assign accept    = cmd_valid && !busy;
    assign drop      = cmd_valid && busy;
    assign hold_done = (st_q == ST_HOLD) && (hold_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            space_q  <= SP_WORD;
            page_q   <= 1'b0;
            pg_q     <= '0;
            idx_q    <= '0;
            s_addr_q <= '0;
            s_data_q <= '0;
            hold_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        case (op_e'(cmd_op))
                            OP_WCOMMIT, OP_BCOMMIT: begin
                                st_q    <= ST_WALK;
                                idx_q   <= '0;
                                page_q  <= 1'b1;
                                pg_q    <= cmd_addr[ADDR_W-1:OFF_BITS];
                                space_q <= (op_e'(cmd_op) == OP_BCOMMIT) ? SP_BYTE : SP_WORD;
                            end
                            OP_BWRITE: begin
                                st_q     <= ST_ERASE;
                                page_q   <= 1'b0;
                                space_q  <= SP_BYTE;
                                s_addr_q <= cmd_addr;
                                s_data_q <= cmd_data;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WALK: begin
                    if (idx_q == LAST_IDX) begin
                        st_q   <= ST_HOLD;
                        hold_q <= HOLD_LOAD;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_ERASE: st_q <= ST_PROG;
                ST_PROG: begin
                    st_q   <= ST_HOLD;
                    hold_q <= HOLD_LOAD;
                end
                ST_HOLD: begin
                    if (hold_q == '0) begin
                        st_q <= ST_IDLE;
                    end else begin
                        hold_q <= hold_q - 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (drop && (err_q != CNT_MAX)) begin
            err_q <= err_q + 1'b1;
        end
    end

    assign err_cnt   = err_q;
    assign walk_idx  = idx_q;
    assign walk_byte = (space_q == SP_BYTE);
    assign clr_word  = hold_done && page_q && (space_q == SP_WORD);
    assign clr_byte  = hold_done && page_q && (space_q == SP_BYTE);

    always_comb begin
        wr_en    = 1'b0;
        wr_erase = 1'b0;
        wr_space = (space_q == SP_BYTE);
        wr_addr  = s_addr_q;
        wr_data  = {8'h00, s_data_q};
        unique case (st_q)
            ST_WALK: begin
                wr_en   = ent_ok;
                wr_addr = {pg_q, idx_q};
                wr_data = ent_data;
            end
            ST_ERASE: begin
                wr_en    = 1'b1;
                wr_erase = 1'b1;
                wr_data  = {8'h00, ERASED_BYTE};
            end
            ST_PROG: wr_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/nvm_page_buffer.sv
module nvm_page_buffer
    import nvm_pb_pkg::*;
#(
    parameter int OFF_BITS    = 6,
    parameter int PAGE_BITS   = 7,
    parameter int BUSY_CYCLES = 64,
    parameter int CNT_W       = 8,
    localparam int ADDR_W     = OFF_BITS + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic              busy,
    output logic [CNT_W-1:0]  err_cnt,
    output logic              wr_en,
    output logic              wr_erase,
    output logic              wr_space,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data
);
    logic                accept;
    logic [OFF_BITS-1:0] walk_idx;
    logic                walk_byte;
    logic                clr_word;
    logic                clr_byte;
    logic                w_ok;
    logic [15:0]         w_word;
    logic                b_ok;
    logic [7:0]          b_byte;
    logic                ent_ok;
    logic [15:0]         ent_data;
    logic                ld_lo;
    logic                ld_hi;
    logic                ld_b;

    assign ld_lo = accept && (cmd_op == OP_WLOAD_LO);
    assign ld_hi = accept && (cmd_op == OP_WLOAD_HI);
    assign ld_b  = accept && (cmd_op == OP_BLOAD);

    nvm_pb_wordbuf #(.OFF_BITS(OFF_BITS)) u_wbuf (
        .clk     (clk),
        .rst     (rst),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_off  (cmd_addr[OFF_BITS-1:0]),
        .ld_data (cmd_data),
        .clr     (clr_word),
        .rd_idx  (walk_idx),
        .rd_ok   (w_ok),
        .rd_word (w_word)
    );

    nvm_pb_bytebuf #(.OFF_BITS(OFF_BITS)) u_bbuf (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld_b),
        .ld_off  (cmd_addr[OFF_BITS-1:0]),
        .ld_data (cmd_data),
        .clr     (clr_byte),
        .rd_idx  (walk_idx),
        .rd_ok   (b_ok),
        .rd_byte (b_byte)
    );

    assign ent_ok   = walk_byte ? b_ok : w_ok;
    assign ent_data = walk_byte ? {8'h00, b_byte} : w_word;

    nvm_pb_seq #(
        .OFF_BITS    (OFF_BITS),
        .PAGE_BITS   (PAGE_BITS),
        .BUSY_CYCLES (BUSY_CYCLES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .ent_ok    (ent_ok),
        .ent_data  (ent_data),
        .accept    (accept),
        .busy      (busy),
        .err_cnt   (err_cnt),
        .walk_idx  (walk_idx),
        .walk_byte (walk_byte),
        .clr_word  (clr_word),
        .clr_byte  (clr_byte),
        .wr_en     (wr_en),
        .wr_erase  (wr_erase),
        .wr_space  (wr_space),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

endmodule

// File: rtl/nvm_page_buffer_chk.sv
module nvm_page_buffer_chk
    import nvm_pb_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              busy,
    input logic [CNT_W-1:0]  err_cnt,
    input logic              wr_en,
    input logic              wr_erase,
    input logic [ADDR_W-1:0] wr_addr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!busy && (err_cnt == '0) && !wr_en)); // R1

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy); // R11

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && op_starts_busy(cmd_op)) |=> busy); // R7

    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && !op_starts_busy(cmd_op)) |=> (!busy && !wr_en)); // R10

    AST_DROP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy && (err_cnt != CNT_MAX)) |=> (err_cnt == $past(err_cnt) + 1'b1)); // R8

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && busy) |=> $stable(err_cnt)); // R8

    AST_ERASE_THEN_PROG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_erase) |=> (wr_en && !wr_erase && (wr_addr == $past(wr_addr)))); // R6

endmodule

bind nvm_page_buffer nvm_page_buffer_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .err_cnt   (err_cnt),
    .wr_en     (wr_en),
    .wr_erase  (wr_erase),
    .wr_addr   (wr_addr)
);

// File: tb/tb_nvm_page_buffer.sv
`timescale 1ns/1ps
module tb_nvm_page_buffer;
    localparam int OFF_BITS    = 3;
    localparam int PAGE_BITS   = 4;
    localparam int BUSY_CYCLES = 5;
    localparam int CNT_W       = 3;
    localparam int ADDR_W      = OFF_BITS + PAGE_BITS;
    localparam int DEPTH       = 1 << OFF_BITS;
    localparam int NLOC        = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = 8'h00;
    logic              busy;
    logic [CNT_W-1:0]  err_cnt;
    logic              wr_en;
    logic              wr_erase;
    logic              wr_space;
    logic [ADDR_W-1:0] wr_addr;
    logic [15:0]       wr_data;

    nvm_page_buffer #(
        .OFF_BITS    (OFF_BITS),
        .PAGE_BITS   (PAGE_BITS),
        .BUSY_CYCLES (BUSY_CYCLES),
        .CNT_W       (CNT_W)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .busy      (busy),
        .err_cnt   (err_cnt),
        .wr_en     (wr_en),
        .wr_erase  (wr_erase),
        .wr_space  (wr_space),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int erase_count = 0;
    int order_bad = 0;
    int cycles = 0;
    logic [ADDR_W-1:0] last_erase_addr = '0;
    logic [ADDR_W-1:0] last_walk_addr = '0;
    logic              last_walk_vld = 1'b0;
    logic [15:0] prog_m [NLOC];
    logic [7:0]  data_m [NLOC];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // model of the array, updated from the strobes
    always @(negedge clk) begin
        cycles++;
        if (!busy) last_walk_vld = 1'b0;
        if (wr_en) begin
            wr_count++;
            if (wr_space == 1'b0) begin
                prog_m[wr_addr] = wr_data;
            end else if (wr_erase) begin
                data_m[wr_addr] = 8'hFF;
                erase_count++;
                last_erase_addr = wr_addr;
            end else begin
                data_m[wr_addr] = wr_data[7:0];
            end
            if (!wr_erase && last_walk_vld && wr_addr <= last_walk_addr && wr_addr != last_erase_addr)
                order_bad++;
            last_walk_addr = wr_addr;
            last_walk_vld  = 1'b1;
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [ADDR_W-1:0] mk(input int page, input int off);
        return ADDR_W'((page << OFF_BITS) | off);
    endfunction

    task automatic send(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 err_cnt", int'(err_cnt), 0);
        chk("R1 wr_en", int'(wr_en), 0);
    endtask

    task automatic t_word_page();
        int n;
        int w0;
        w0 = wr_count;
        send(3'd0, mk(3, 0), 8'h34);
        send(3'd1, mk(3, 0), 8'h12);
        send(3'd0, mk(3, 7), 8'hCD);
        send(3'd1, mk(3, 7), 8'hAB);
        send(3'd0, mk(3, 2), 8'h77);          // R4 low only
        send(3'd1, mk(3, 5), 8'h99);          // R3 high first
        send(3'd0, mk(3, 5), 8'h55);
        send(3'd1, mk(3, 5), 8'h66);
        chk("R7 load keeps idle", int'(busy), 0);
        send(3'd2, mk(3, 5), 8'h00);
        wait_idle(n);
        chk("R7 page busy length", n, DEPTH + BUSY_CYCLES);
        chk("R2 slot0 word", int'(prog_m[mk(3, 0)]), 16'h1234);
        chk("R2 last slot word", int'(prog_m[mk(3, 7)]), 16'hABCD);
        chk("R2 strobe count", wr_count - w0, 2);
        chk("R2 ascending order", order_bad, 0);
        chk("R4 low-only slot untouched", int'(prog_m[mk(3, 2)]), 16'hBEEF);
        chk("R3 invalid slot untouched", int'(prog_m[mk(3, 5)]), 16'hBEEF);
    endtask

    task automatic t_clear();
        int n;
        int w0;
        w0 = wr_count;
        send(3'd2, mk(4, 0), 8'h00);
        wait_idle(n);
        chk("R9 word buffer cleared", wr_count - w0, 0);
        chk("R9 page 4 untouched", int'(prog_m[mk(4, 0)]), 16'hBEEF);
    endtask

    task automatic t_byte_page();
        int n;
        int w0;
        w0 = wr_count;
        send(3'd3, mk(2, 1), 8'h11);
        send(3'd3, mk(2, 1), 8'h22);
        send(3'd3, mk(2, 6), 8'h66);
        send(3'd4, mk(2, 3), 8'h00);
        wait_idle(n);
        chk("R7 byte page busy length", n, DEPTH + BUSY_CYCLES);
        chk("R5 last load wins", int'(data_m[mk(2, 1)]), 8'h22);
        chk("R5 slot6", int'(data_m[mk(2, 6)]), 8'h66);
        chk("R5 unloaded untouched", int'(data_m[mk(2, 0)]), 8'h5A);
        chk("R5 strobe count", wr_count - w0, 2);
        chk("R5 word array untouched", int'(prog_m[mk(2, 1)]), 16'hBEEF);
    endtask

    task automatic t_single();
        int n;
        int w0;
        int e0;
        w0 = wr_count;
        e0 = erase_count;
        send(3'd5, 7'h45, 8'h3C);
        wait_idle(n);
        chk("R7 single busy length", n, 2 + BUSY_CYCLES);
        chk("R6 value written", int'(data_m[7'h45]), 8'h3C);
        chk("R6 strobe count", wr_count - w0, 2);
        chk("R6 one erase", erase_count - e0, 1);
        chk("R6 erase address", int'(last_erase_addr), 7'h45);
    endtask

    task automatic t_drop();
        int n;
        int w0;
        send(3'd3, mk(5, 3), 8'h33);
        w0 = wr_count;
        send(3'd4, mk(5, 0), 8'h00);
        send(3'd3, mk(5, 4), 8'h44);          // dropped
        send(3'd2, mk(6, 0), 8'h00);          // dropped
        chk("R8 two drops counted", int'(err_cnt), 2);
        wait_idle(n);
        chk("R8 commit unaffected", wr_count - w0, 1);
        chk("R8 slot3 written", int'(data_m[mk(5, 3)]), 8'h33);
        w0 = wr_count;
        send(3'd4, mk(5, 0), 8'h00);
        cmd_valid = 1'b1;
        cmd_op    = 3'd3;
        cmd_addr  = mk(5, 4);
        cmd_data  = 8'h44;
        repeat (6) @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8 saturates", int'(err_cnt), 7);
        wait_idle(n);
        chk("R8 dropped load not written", wr_count - w0, 0);
        chk("R8 slot4 untouched", int'(data_m[mk(5, 4)]), 8'h5A);
    endtask

    task automatic t_reserved();
        int n;
        int w0;
        w0 = wr_count;
        send(3'd6, mk(6, 2), 8'hEE);
        chk("R10 op6 no busy", int'(busy), 0);
        send(3'd7, mk(6, 2), 8'hEE);
        chk("R10 op7 no busy", int'(busy), 0);
        chk("R10 err unchanged", int'(err_cnt), 7);
        send(3'd4, mk(6, 0), 8'h00);
        wait_idle(n);
        send(3'd2, mk(6, 0), 8'h00);
        wait_idle(n);
        chk("R10 nothing loaded", wr_count - w0, 0);
        chk("R10 location untouched", int'(data_m[mk(6, 2)]), 8'h5A);
    endtask

    initial begin
        for (int i = 0; i < NLOC; i++) begin
            prog_m[i] = 16'hBEEF;
            data_m[i] = 8'h5A;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word_page();
        t_clear();
        t_byte_page();
        t_single();
        t_drop();
        t_reserved();
        chk("R11 no stray strobe idle", int'(wr_en), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule